// File: doc/BRIEF.md
# Keyed Table Write-Lock Guard

This block sits in front of a configuration table, such as a sequencer instruction table, and decides whether the table's write strobes reach storage. A register write port carries all control writes. The block watches two of its addresses: a key register and a lock control register. A lock or unlock command takes effect only when the register write just before it put the 32-bit magic value into the key register. Any other command is dropped without effect.

The guard is armed by a correct key write and disarmed by every other register write, including the command write itself. Cycles with no register write leave it as it is. While the table is locked, each table write-enable lane is forced low. While it is unlocked, each lane passes straight through with no added register stage.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset the table is unlocked (`locked_o` = 0) and the guard is disarmed.
- R2: Writing 0x0000_0001 to the lock control address (0x1C) while armed sets `locked_o` to 1 from the cycle after that write.
- R3: Writing 0x0000_0002 to the lock control address while armed clears `locked_o` to 0 from the cycle after that write.
- R4: A lock or unlock command with no key write before it leaves `locked_o` unchanged.
- R5: A write of any value other than 0x5AF0_5AF0 to the key address (0x18) disarms the guard, so the command that follows is ignored.
- R6: A register write to any other address between the key write and the command disarms the guard, so the command is ignored.
- R7: Every write to the lock control address disarms the guard, so a second command needs a fresh key write.
- R8: Writing 0x0 or 0x3 to the lock control address while armed leaves `locked_o` unchanged and disarms the guard.
- R9: While unlocked, each `tbl_we_i` lane appears on `tbl_we_o` in the same cycle. While locked, every `tbl_we_o` lane is 0.
- R10: Clock cycles with no register write do not disarm the guard, so a key write followed by idle cycles and then a command still takes effect.
- R11: A correct key write repeated before the command keeps the guard armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | DATA_W | Register write data |
| tbl_we_i | input | TBL_PORTS | Table write-enable lanes from the requester |
| tbl_we_o | output | TBL_PORTS | Table write-enable lanes toward storage |
| locked_o | output | 1 | 1 while the table is locked |

## Verification
The bench builds the guard with three write-enable lanes and leaves the other parameters at their defaults: 8-bit addresses, 32-bit data, key address 0x18, control address 0x1C. With three lanes, masking can be checked on distinct lane patterns and on each lane separately, which a single lane would not show. Directed sequences cover the following cases:
- a wrong key value;
- a stray write to another address;
- a repeated key write;
- idle gaps between the key write and the command;
- the unused command codes;
- back-to-back commands.

In each case the bench observes whether the lock state changes, and does so only through `locked_o` and the gated lanes.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2
  } lock_cmd_e;
endpackage

// File: rtl/lkg_key_arm.sv
module lkg_key_arm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h18,
  parameter logic [DATA_W-1:0] KEY_VAL  = 32'h5AF0_5AF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              armed_o
);
  logic key_hit;
  logic armed_q;

  assign key_hit = (wr_addr_i == KEY_ADDR) && (wr_data_i == KEY_VAL);

  // every register write re-decides arming; idle cycles hold it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= key_hit;
  end

  assign armed_o = armed_q;

  p_stray_write_disarms_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != KEY_ADDR) |=> !armed_o);
  p_bad_key_disarms_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != KEY_VAL) |=> !armed_o);
  p_idle_keeps_arm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(armed_o));
  p_rekey_stays_armed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && wr_en_i && wr_addr_i == KEY_ADDR && wr_data_i == KEY_VAL) |=> armed_o);
endmodule

// File: rtl/lkg_lock_state.sv
module lkg_lock_state
  import lock_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h1C,
  parameter logic [DATA_W-1:0] LOCK_CODE   = 32'h1,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 32'h2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              armed_i,
  output logic              locked_o
);
  lock_cmd_e cmd;
  logic      locked_q;

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en_i && armed_i && wr_addr_i == CTRL_ADDR) begin
      if (wr_data_i == LOCK_CODE)        cmd = CMD_LOCK;
      else if (wr_data_i == UNLOCK_CODE) cmd = CMD_UNLOCK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) locked_q <= 1'b0;
    else begin
      case (cmd)
        CMD_LOCK:   locked_q <= 1'b1;
        CMD_UNLOCK: locked_q <= 1'b0;
        default:    locked_q <= locked_q;
      endcase
    end
  end

  assign locked_o = locked_q;

  p_unarmed_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(locked_o));
  p_lock_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && wr_en_i && wr_addr_i == CTRL_ADDR && wr_data_i == LOCK_CODE) |=> locked_o);
  p_unlock_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && wr_en_i && wr_addr_i == CTRL_ADDR && wr_data_i == UNLOCK_CODE) |=> !locked_o);
  p_other_code_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CTRL_ADDR && wr_data_i != LOCK_CODE && wr_data_i != UNLOCK_CODE)
      |=> $stable(locked_o));
endmodule

// File: rtl/lkg_we_gate.sv
module lkg_we_gate #(
  parameter int TBL_PORTS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 locked_i,
  input  logic [TBL_PORTS-1:0] tbl_we_i,
  output logic [TBL_PORTS-1:0] tbl_we_o
);
  for (genvar g = 0; g < TBL_PORTS; g++) begin : g_lane
    assign tbl_we_o[g] = tbl_we_i[g] & ~locked_i;
  end

  p_locked_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> (tbl_we_o == '0));
  p_unlocked_passes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (tbl_we_o == tbl_we_i));
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TBL_PORTS = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR    = 8'h18,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h1C,
  parameter logic [DATA_W-1:0] KEY_VAL     = 32'h5AF0_5AF0,
  parameter logic [DATA_W-1:0] LOCK_CODE   = 32'h1,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 32'h2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [TBL_PORTS-1:0] tbl_we_i,
  output logic [TBL_PORTS-1:0] tbl_we_o,
  output logic                 locked_o
);
  logic armed;
  logic locked;

  lkg_key_arm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .KEY_VAL(KEY_VAL)
  ) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .armed_o(armed)
  );

  lkg_lock_state #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .LOCK_CODE(LOCK_CODE), .UNLOCK_CODE(UNLOCK_CODE)
  ) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .armed_i(armed), .locked_o(locked)
  );

  lkg_we_gate #(.TBL_PORTS(TBL_PORTS)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .locked_i(locked),
    .tbl_we_i(tbl_we_i), .tbl_we_o(tbl_we_o)
  );

  assign locked_o = locked;

  p_cmd_disarms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CTRL_ADDR) |=> !armed);
  p_reset_unlocked_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!locked_o && !armed));
endmodule

// File: tb/cfg_lock_guard_bench.sv
module cfg_lock_guard_bench;
  localparam int NP = 3;
  localparam logic [7:0]  KA  = 8'h18;
  localparam logic [7:0]  CA  = 8'h1C;
  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [NP-1:0] we_in = '0;
  logic [NP-1:0] we_out;
  logic          locked;
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_lock_guard #(.TBL_PORTS(NP)) u_cfg_lock_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tbl_we_i(we_in), .tbl_we_o(we_out), .locked_o(locked)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register write; returns at the negedge after the capturing posedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic force_lock();
    wr(KA, KEY); wr(CA, 32'h1);
  endtask

  task automatic force_unlock();
    wr(KA, KEY); wr(CA, 32'h2);
  endtask

  task automatic t_reset();
    chk("R1 reset locked", {31'b0, locked}, 32'h0);
    wr(CA, 32'h1);
    chk("R1 reset disarmed", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_lock_unlock();
    force_lock();
    chk("R2 key+lock", {31'b0, locked}, 32'h1);
    force_unlock();
    chk("R3 key+unlock", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_no_key();
    wr(CA, 32'h1);
    chk("R4 lock without key", {31'b0, locked}, 32'h0);
    force_lock();
    wr(CA, 32'h2);
    chk("R4 unlock without key", {31'b0, locked}, 32'h1);
    force_unlock();
  endtask

  task automatic t_bad_key();
    wr(KA, 32'h5AF0_5AF1); wr(CA, 32'h1);
    chk("R5 wrong key", {31'b0, locked}, 32'h0);
    wr(KA, KEY); wr(KA, 32'h0); wr(CA, 32'h1);
    chk("R5 good then bad key", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_stray();
    wr(KA, KEY); wr(8'h20, KEY); wr(CA, 32'h1);
    chk("R6 stray write", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_single_use();
    force_lock();
    wr(CA, 32'h2);
    chk("R7 second cmd needs key", {31'b0, locked}, 32'h1);
    force_unlock();
    wr(CA, 32'h1);
    chk("R7 relock needs key", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_other_codes();
    force_lock();
    wr(KA, KEY); wr(CA, 32'h3);
    chk("R8 code 3 no effect", {31'b0, locked}, 32'h1);
    wr(CA, 32'h2);
    chk("R8 code 3 disarms", {31'b0, locked}, 32'h1);
    wr(KA, KEY); wr(CA, 32'h0);
    chk("R8 code 0 no effect", {31'b0, locked}, 32'h1);
    wr(CA, 32'h2);
    chk("R8 code 0 disarms", {31'b0, locked}, 32'h1);
    force_unlock();
  endtask

  task automatic t_gate();
    @(negedge clk);
    we_in = 3'b101; #1;
    chk("R9 pass 101", {29'b0, we_out}, 32'h5);
    we_in = 3'b010; #1;
    chk("R9 pass 010", {29'b0, we_out}, 32'h2);
    force_lock();
    for (int i = 0; i < NP; i++) begin
      we_in = NP'(1) << i; #1;
      chk("R9 lane blocked", {29'b0, we_out}, 32'h0);
    end
    we_in = '1; #1;
    chk("R9 all blocked", {29'b0, we_out}, 32'h0);
    force_unlock();
    #1;
    chk("R9 pass after unlock", {29'b0, we_out}, 32'h7);
    we_in = '0;
  endtask

  task automatic t_idle_gap();
    wr(KA, KEY); idle(5); wr(CA, 32'h1);
    chk("R10 idle keeps arm", {31'b0, locked}, 32'h1);
    wr(KA, KEY); idle(3); wr(CA, 32'h2);
    chk("R10 idle unlock", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_rekey();
    wr(KA, KEY); wr(KA, KEY); wr(CA, 32'h1);
    chk("R11 repeated key", {31'b0, locked}, 32'h1);
    force_unlock();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    chk("R1 reset held", {31'b0, locked}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock_unlock();
    t_no_key();
    t_bad_key();
    t_stray();
    t_single_use();
    t_other_codes();
    t_gate();
    t_idle_gap();
    t_rekey();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule